// File: doc/BRIEF.md
# Read-Before-Write Implication Logic Controller

This block sequences stateful implication and clear operations on a small bit-addressable storage array. Each stored bit models a resistive cell, where 1 is the low-resistance state and 0 is the high-resistance state. Every operation starts with a read/compare cycle. A per-row detector then decides whether the destination bit has to change. Only the rows that need to switch receive a write strobe. All other rows see no pulse, which models drivers left in high impedance. Implication and clear together form a complete logic set, so any Boolean function can be built from a sequence of these two operations.

An operation is started by asserting `go` with an opcode and operand addresses. In row-parallel mode the operation applies to every row selected by `row_mask`, with operand P in column `col_p` and destination Q in column `col_q`. In column mode both operands lie in column `col_p`: P is in row `row_p` and Q is in row `row_q`. The controller exposes per-row read, set and reset strobes, a one-cycle completion flag and a running count of the row pulses actually issued.

Top module: `rbw_imply_ctrl`

## Requirements
- R1: While `rst` is high and after its release, all strobes and `done` are 0, `pulse_cnt` is 0 and every stored bit is 0.
- R2: Implication (op = 2'b01) leaves each destination bit equal to (NOT P) OR Q and never changes the P bit.
- R3: Implication drives `set_pls` on a row only when both P and Q read 0 on that row. In every other case that row receives no pulse.
- R4: Clear (op = 2'b10) drives `rst_pls` on a row only when Q reads 1, and leaves Q at 0. A Q already at 0 gets no pulse.
- R5: An operation accepted at a clock edge shows `rd_en` during the next cycle and the write strobes in the cycle after that. It then asserts `done` for exactly one cycle, with no strobe active in that cycle.
- R6: In row-parallel mode (`vert` = 0), only rows with their `row_mask` bit set are read or written. No strobe of any kind reaches the other rows, and their bits keep their values.
- R7: In column mode (`vert` = 1), implication reads rows `row_p` and `row_q`, with P at (`row_p`, `col_p`) and Q at (`row_q`, `col_p`), and may pulse only row `row_q`. Clear reads and may pulse only (`row_q`, `col_p`).
- R8: Opcodes 2'b00 and 2'b11 start nothing: they produce no strobe and no `done`, and leave `pulse_cnt` unchanged.
- R9: `pulse_cnt` grows by the number of row strobes issued in each write cycle and by nothing else.
- R10: A `go` raised while an operation is in progress is ignored.
- R11: `set_pls` and `rst_pls` are never active in the same cycle, and a write strobe only hits rows that were read in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, sampled while idle |
| op | input | 2 | 00 no-op, 01 implication, 10 clear, 11 reserved (no-op) |
| vert | input | 1 | 0 row-parallel, 1 column mode |
| row_p | input | RW | P row in column mode |
| row_q | input | RW | Q row in column mode |
| col_p | input | CW | P column (both operands in column mode) |
| col_q | input | CW | Q column in row-parallel mode |
| row_mask | input | ROWS | Active rows in row-parallel mode |
| rd_en | output | ROWS | Per-row read strobe |
| set_pls | output | ROWS | Per-row set (write 1) strobe |
| rst_pls | output | ROWS | Per-row reset (write 0) strobe |
| done | output | 1 | One-cycle completion flag |
| pulse_cnt | output | CNT_W | Count of row pulses issued |

## Verification
The checker assumes that `rst` is held high for at least two clock edges before operations start. It also assumes that `pulse_cnt` does not wrap during a run, since its step rule has no wrap case. The bench keeps the operation count far below the counter range and waits for `done` before each new request, except for one deliberate overlap that tests the ignore rule. The bench also keeps all addresses inside the array bounds.

// File: rtl/rbw_imply_pkg.sv
package rbw_imply_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_IMPLY = 2'b01,
        OP_FALSE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } st_e;

    function automatic logic op_starts(input op_e o);
        return (o == OP_IMPLY) || (o == OP_FALSE);
    endfunction

endpackage

// File: rtl/rbw_cell_array.sv
module rbw_cell_array #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vert,
    input  logic [RW-1:0]   row_p,
    input  logic [CW-1:0]   col_p,
    input  logic [CW-1:0]   col_q,
    input  logic            wr_en,
    input  logic [ROWS-1:0] set_m,
    input  logic [ROWS-1:0] clr_m,
    output logic [ROWS-1:0] p_bit,
    output logic [ROWS-1:0] q_bit
);
    logic [COLS-1:0] cells [ROWS];
    logic [CW-1:0]   q_col;

    assign q_col = vert ? col_p : col_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // operand read ports
        assign p_bit[r] = vert ? cells[row_p][col_p] : cells[r][col_p];
        assign q_bit[r] = cells[r][q_col];

        always_ff @(posedge clk) begin
            if (rst) begin
                cells[r] <= '0;
            end else if (wr_en) begin
                if (set_m[r])
                    cells[r][q_col] <= 1'b1;
                else if (clr_m[r])
                    cells[r][q_col] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rbw_row_detect.sv
module rbw_row_detect
    import rbw_imply_pkg::*;
#(
    parameter int ROWS = 4,
    localparam int RW = $clog2(ROWS)
) (
    input  op_e             op,
    input  logic            vert,
    input  logic [RW-1:0]   row_p,
    input  logic [RW-1:0]   row_q,
    input  logic [ROWS-1:0] row_mask,
    input  logic [ROWS-1:0] p_bit,
    input  logic [ROWS-1:0] q_bit,
    output logic [ROWS-1:0] read_m,
    output logic [ROWS-1:0] need_set,
    output logic [ROWS-1:0] need_clr
);
    for (genvar r = 0; r < ROWS; r++) begin : g_det
        logic dest_row;
        logic src_row;

        assign dest_row = vert ? (row_q == RW'(r)) : row_mask[r];
        assign src_row  = vert && (op == OP_IMPLY) && (row_p == RW'(r));
        assign read_m[r] = dest_row | src_row;

        // digital model of the sense comparator
        assign need_set[r] = dest_row && (op == OP_IMPLY) && !p_bit[r] && !q_bit[r];
        assign need_clr[r] = dest_row && (op == OP_FALSE) && q_bit[r];
    end
endmodule

// File: rtl/rbw_sequencer.sv
module rbw_sequencer
    import rbw_imply_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 8,
    parameter int CNT_W = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [1:0]      op_in,
    input  logic            vert_in,
    input  logic [RW-1:0]   row_p_in,
    input  logic [RW-1:0]   row_q_in,
    input  logic [CW-1:0]   col_p_in,
    input  logic [CW-1:0]   col_q_in,
    input  logic [ROWS-1:0] mask_in,
    input  logic [ROWS-1:0] read_m,
    input  logic [ROWS-1:0] need_set,
    input  logic [ROWS-1:0] need_clr,
    output op_e             op_l,
    output logic            vert_l,
    output logic [RW-1:0]   row_p_l,
    output logic [RW-1:0]   row_q_l,
    output logic [CW-1:0]   col_p_l,
    output logic [CW-1:0]   col_q_l,
    output logic [ROWS-1:0] mask_l,
    output logic            wr_en,
    output logic [ROWS-1:0] set_m,
    output logic [ROWS-1:0] clr_m,
    output logic [ROWS-1:0] rd_en,
    output logic [ROWS-1:0] set_pls,
    output logic [ROWS-1:0] rst_pls,
    output logic            done,
    output logic [CNT_W-1:0] pulse_cnt
);
    st_e st;
    logic [ROWS-1:0] hit_set, hit_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_l      <= OP_NOP;
            vert_l    <= 1'b0;
            row_p_l   <= '0;
            row_q_l   <= '0;
            col_p_l   <= '0;
            col_q_l   <= '0;
            mask_l    <= '0;
            hit_set   <= '0;
            hit_clr   <= '0;
            pulse_cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (go && op_starts(op_e'(op_in))) begin
                    op_l    <= op_e'(op_in);
                    vert_l  <= vert_in;
                    row_p_l <= row_p_in;
                    row_q_l <= row_q_in;
                    col_p_l <= col_p_in;
                    col_q_l <= col_q_in;
                    mask_l  <= mask_in;
                    st      <= ST_READ;
                end
                ST_READ: begin
                    hit_set <= need_set;
                    hit_clr <= need_clr;
                    st      <= ST_WRITE;
                end
                ST_WRITE: begin
                    pulse_cnt <= pulse_cnt + CNT_W'($countones(hit_set | hit_clr));
                    st        <= ST_FIN;
                end
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign wr_en   = (st == ST_WRITE);
    assign set_m   = hit_set;
    assign clr_m   = hit_clr;
    assign rd_en   = (st == ST_READ) ? read_m : '0;
    assign set_pls = wr_en ? hit_set : '0;
    assign rst_pls = wr_en ? hit_clr : '0;
    assign done    = (st == ST_FIN);
endmodule

// File: rtl/rbw_imply_ctrl.sv
module rbw_imply_ctrl
    import rbw_imply_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 8,
    parameter int CNT_W = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [1:0]       op,
    input  logic             vert,
    input  logic [RW-1:0]    row_p,
    input  logic [RW-1:0]    row_q,
    input  logic [CW-1:0]    col_p,
    input  logic [CW-1:0]    col_q,
    input  logic [ROWS-1:0]  row_mask,
    output logic [ROWS-1:0]  rd_en,
    output logic [ROWS-1:0]  set_pls,
    output logic [ROWS-1:0]  rst_pls,
    output logic             done,
    output logic [CNT_W-1:0] pulse_cnt
);
    op_e             op_l;
    logic            vert_l, wr_en;
    logic [RW-1:0]   row_p_l, row_q_l;
    logic [CW-1:0]   col_p_l, col_q_l;
    logic [ROWS-1:0] mask_l, set_m, clr_m, p_bit, q_bit;
    logic [ROWS-1:0] read_m, need_set, need_clr;

    rbw_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
        .clk(clk), .rst(rst), .vert(vert_l), .row_p(row_p_l),
        .col_p(col_p_l), .col_q(col_q_l), .wr_en(wr_en),
        .set_m(set_m), .clr_m(clr_m), .p_bit(p_bit), .q_bit(q_bit)
    );

    rbw_row_detect #(.ROWS(ROWS)) u_detect (
        .op(op_l), .vert(vert_l), .row_p(row_p_l), .row_q(row_q_l),
        .row_mask(mask_l), .p_bit(p_bit), .q_bit(q_bit),
        .read_m(read_m), .need_set(need_set), .need_clr(need_clr)
    );

    rbw_sequencer #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .go(go), .op_in(op), .vert_in(vert),
        .row_p_in(row_p), .row_q_in(row_q), .col_p_in(col_p),
        .col_q_in(col_q), .mask_in(row_mask),
        .read_m(read_m), .need_set(need_set), .need_clr(need_clr),
        .op_l(op_l), .vert_l(vert_l), .row_p_l(row_p_l), .row_q_l(row_q_l),
        .col_p_l(col_p_l), .col_q_l(col_q_l), .mask_l(mask_l),
        .wr_en(wr_en), .set_m(set_m), .clr_m(clr_m),
        .rd_en(rd_en), .set_pls(set_pls), .rst_pls(rst_pls),
        .done(done), .pulse_cnt(pulse_cnt)
    );
endmodule

// File: rtl/rbw_imply_ctrl_chk.sv
module rbw_imply_ctrl_chk #(
    parameter int ROWS  = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [ROWS-1:0]  rd_en,
    input logic [ROWS-1:0]  set_pls,
    input logic [ROWS-1:0]  rst_pls,
    input logic             done,
    input logic [CNT_W-1:0] pulse_cnt
);
    AST_SET_RST_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((|set_pls) && (|rst_pls))); // R11

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        ((set_pls | rst_pls) != '0) |-> (((set_pls | rst_pls) & ~$past(rd_en)) == '0)); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_en == '0 && set_pls == '0 && rst_pls == '0)); // R5

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rd_en != '0) |=> !done); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt == $past(pulse_cnt) + CNT_W'($countones($past(set_pls | rst_pls)))
        || $past(set_pls | rst_pls) != '0); // R9

    AST_CNT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((set_pls | rst_pls) != '0) |=>
            pulse_cnt == $past(pulse_cnt) + CNT_W'($countones($past(set_pls | rst_pls)))); // R9
endmodule

bind rbw_imply_ctrl rbw_imply_ctrl_chk #(.ROWS(ROWS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .set_pls(set_pls),
    .rst_pls(rst_pls), .done(done), .pulse_cnt(pulse_cnt)
);

// File: tb/rbw_imply_ctrl_test.sv
module rbw_imply_ctrl_test;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0;
    logic [1:0] op = 2'b00;
    logic vert = 1'b0;
    logic [1:0] row_p = '0, row_q = '0;
    logic [2:0] col_p = '0, col_q = '0;
    logic [3:0] row_mask = '0;
    logic [3:0] rd_en, set_pls, rst_pls;
    logic done;
    logic [CNT_W-1:0] pulse_cnt;

    always #4 clk = ~clk;

    rbw_imply_ctrl #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .go(go), .op(op), .vert(vert),
        .row_p(row_p), .row_q(row_q), .col_p(col_p), .col_q(col_q),
        .row_mask(row_mask), .rd_en(rd_en), .set_pls(set_pls),
        .rst_pls(rst_pls), .done(done), .pulse_cnt(pulse_cnt)
    );

    typedef struct {
        logic [3:0]  rd;
        logic [3:0]  st;
        logic [3:0]  cl;
        logic [15:0] cnt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [COLS-1:0] mdl [ROWS];
    int tests = 0;
    int fails = 0;
    int exp_cnt = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // driver: predict, push expected item, then issue
    task automatic run_op(input logic [1:0] o, input logic v, input logic [1:0] rp,
                          input logic [1:0] rq, input logic [2:0] cp, input logic [2:0] cq,
                          input logic [3:0] m, input string tag);
        exp_t e;
        e.rd = '0; e.st = '0; e.cl = '0; e.tag = tag;
        if (o == 2'b01 || o == 2'b10) begin
            for (int r = 0; r < ROWS; r++) begin
                logic act, p, q;
                act = v ? (rq == 2'(r)) : m[r];
                p   = v ? mdl[rp][cp] : mdl[r][cp];
                q   = v ? mdl[r][cp] : mdl[r][cq];
                e.rd[r] = act | (v && o == 2'b01 && rp == 2'(r));
                e.st[r] = act && o == 2'b01 && !p && !q;
                e.cl[r] = act && o == 2'b10 && q;
            end
            for (int r = 0; r < ROWS; r++) begin
                if (e.st[r]) mdl[r][v ? cp : cq] = 1'b1;
                if (e.cl[r]) mdl[r][v ? cp : cq] = 1'b0;
            end
            exp_cnt += $countones(e.st) + $countones(e.cl);
            e.cnt = 16'(exp_cnt);
            exp_q.push_back(e);
        end
        @(negedge clk);
        op = o; vert = v; row_p = rp; row_q = rq; col_p = cp; col_q = cq; row_mask = m;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    // monitor: pops expected items as operations appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rd_en != '0) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected operation rd_en", 32'(rd_en), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " rd_en"}, 32'(rd_en), 32'(e.rd));
                    @(negedge clk);
                    check({e.tag, " set_pls"}, 32'(set_pls), 32'(e.st));
                    check({e.tag, " rst_pls"}, 32'(rst_pls), 32'(e.cl));
                    @(negedge clk);
                    check({e.tag, " R5 done"}, 32'(done), 32'h1);
                    check({e.tag, " R9 pulse_cnt"}, 32'(pulse_cnt), 32'(e.cnt));
                    @(negedge clk);
                    check({e.tag, " R5 done single"}, 32'(done), 32'h0);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++) mdl[r] = '0;
        repeat (3) @(negedge clk);
        check("R1 strobes in reset", 32'({rd_en, set_pls, rst_pls, done}), 32'h0);
        check("R1 pulse_cnt in reset", 32'(pulse_cnt), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 strobes after reset", 32'({rd_en, set_pls, rst_pls, done}), 32'h0);

        // R2/R3: all zero -> every masked row sets column 1
        run_op(2'b01, 0, 0, 0, 3'd0, 3'd1, 4'b1111, "R2 R3 imply all zero");
        repeat (4) @(negedge clk);
        // R3: Q already 1 -> no pulses
        run_op(2'b01, 0, 0, 0, 3'd0, 3'd1, 4'b1111, "R3 imply Q=1 no pulse");
        repeat (4) @(negedge clk);
        // R4: clear rows 0,2 then again with no pulses
        run_op(2'b10, 0, 0, 0, 3'd0, 3'd1, 4'b0101, "R4 false Q=1");
        repeat (4) @(negedge clk);
        run_op(2'b10, 0, 0, 0, 3'd0, 3'd1, 4'b0101, "R4 false Q=0 no pulse");
        repeat (4) @(negedge clk);
        // R2: mixed P values, P column 1 must stay unchanged
        run_op(2'b01, 0, 0, 0, 3'd1, 3'd2, 4'b1111, "R2 imply mixed P");
        repeat (4) @(negedge clk);
        run_op(2'b10, 0, 0, 0, 3'd0, 3'd1, 4'b1111, "R2 P column kept");
        repeat (4) @(negedge clk);
        // R6: single-row mask
        run_op(2'b01, 0, 0, 0, 3'd5, 3'd6, 4'b0010, "R6 masked rows");
        repeat (4) @(negedge clk);
        run_op(2'b10, 0, 0, 0, 3'd0, 3'd6, 4'b1111, "R6 unmasked rows untouched");
        repeat (4) @(negedge clk);
        // R7: column mode
        run_op(2'b01, 1, 2'd0, 2'd3, 3'd2, 3'd0, 4'b0000, "R7 vertical imply P=1");
        repeat (4) @(negedge clk);
        run_op(2'b01, 1, 2'd0, 2'd3, 3'd3, 3'd0, 4'b1111, "R7 vertical imply set");
        repeat (4) @(negedge clk);
        run_op(2'b10, 1, 2'd0, 2'd3, 3'd3, 3'd0, 4'b1111, "R7 vertical false");
        repeat (4) @(negedge clk);

        // R8: no-op and reserved opcodes
        for (int k = 0; k < 2; k++) begin
            logic [3:0] seen;
            logic [15:0] c0;
            c0 = pulse_cnt;
            seen = '0;
            run_op(k == 0 ? 2'b00 : 2'b11, 0, 0, 0, 3'd4, 3'd4, 4'b1111, "R8 no-op");
            repeat (5) begin
                @(negedge clk);
                seen = seen | rd_en | set_pls | rst_pls | {3'b000, done};
            end
            check("R8 no activity on no-op", 32'(seen), 32'h0);
            check("R8 pulse_cnt unchanged", 32'(pulse_cnt), 32'(c0));
        end

        // R10: set column 7 on all rows, then a clear raised while busy is ignored
        run_op(2'b01, 0, 0, 0, 3'd4, 3'd7, 4'b1111, "R10 imply col7");
        @(negedge clk);
        op = 2'b10; col_q = 3'd7; row_mask = 4'b1111; vert = 1'b0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (4) @(negedge clk);
        run_op(2'b10, 0, 0, 0, 3'd0, 3'd7, 4'b1111, "R10 busy go ignored");
        repeat (6) @(negedge clk);
        check("R10 no leftover expected items", 32'(exp_q.size()), 32'h0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule